// File: doc/BRIEF.md
# Hardware Event Flag Wait Unit

The unit holds a bank of one-bit event flags. Each flag is raised by a single-cycle pulse from a hardware source, for example a frame start, a frame end or an underrun detector. Several command threads share the bank. A thread presents an event index and a 32-bit control word and keeps its request valid until it receives a grant. One control word can express three kinds of command: wait and then clear, clear only, or set only.

The grant is combinational in the cycle the condition holds. Any update the command asks for is written into the flag at the clock edge that closes that cycle, so the wait and the update act as one atomic step. Threads are served in a fixed order, with the lowest index first. Each thread sees the flag bank as the threads ahead of it have left it in the same cycle. Source indices need not be contiguous, because the bank covers every index below `N_EVENTS` (default 72, at least 66). The asynchronous active-low reset is released to the core through a two-stage synchroniser.

Top module: `evflag_wait_unit`

## Requirements
- R1: While reset is asserted, and for two clock edges after rst_n rises, every flag is 0 and no grant or busy is given, even for a request that is valid. After reset, all flags read 0.
- R2: Control word fields: bits [11:0] are the wait value, bit 15 enables the wait, bits [27:16] are the update value and bit 31 enables the update. A flag is compared with, or written with, 1 when the matching value field is nonzero and 0 when it is zero.
- R3: A request with the wait enabled is granted in any cycle in which its flag equals the wait level. Otherwise busy stays high for that thread and the flag is left unchanged.
- R4: Wait-and-clear (control 0x80008001) is granted when the flag is 1, and the flag becomes 0 at the edge that closes the grant cycle.
- R5: With the wait disabled and the update enabled, the request is granted in the same cycle and the flag takes the update level at the next edge. 0x80010000 sets the flag and 0x80000000 clears it.
- R6: A source pulse in src_set sets its flag at the next edge. A thread waiting on that flag is granted in the cycle after the pulse, not in the cycle of the pulse.
- R7: When a source pulse and a thread update hit the same flag in the same cycle, the flag ends at 1.
- R8: Threads are evaluated from thread 0 upward. When several threads wait on one flag, the lowest-numbered thread is granted. Higher threads test the value that thread leaves behind, so a wait-and-clear by thread 0 keeps the others busy.
- R9: An index of N_EVENTS or more is granted at once. It raises idx_err for that cycle and changes no flag.
- R10: A control word with both the wait and the update disabled is granted at once and changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | N_EVENTS | One-cycle set pulses from the hardware sources, one bit per flag |
| req_valid | input | N_THREADS | Request valid, one bit per thread, held until the grant |
| req_index | input | N_THREADS*IDX_W | Event index per thread (thread i at bits i*IDX_W upward) |
| req_ctrl | input | N_THREADS*32 | Control word per thread (thread i at bits i*32 upward) |
| grant | output | N_THREADS | Request satisfied in this cycle |
| busy | output | N_THREADS | Thread blocked on its wait condition |
| idx_err | output | N_THREADS | Event index out of range in this cycle |

## Verification
Two things can meet on one flag in a single cycle: a source set pulse and a thread's own update. The bench provokes this by holding a wait-and-clear on a flag that is already set while pulsing that flag's source in the same cycle. The wait-and-clear must be granted. A probe in the next cycle must then find the flag still at 1. A second collision, in which three threads wait on one flag, is judged by the grant and busy vectors and by which thread is granted after a later source pulse.

// File: rtl/evw_pkg.sv
package evw_pkg;
  localparam int CTRL_W      = 32;
  localparam int WAIT_LO     = 0;
  localparam int WAIT_HI     = 11;
  localparam int WAIT_EN_BIT = 15;
  localparam int UPD_LO      = 16;
  localparam int UPD_HI      = 27;
  localparam int UPD_EN_BIT  = 31;

  typedef struct packed {
    logic wait_en;
    logic wait_level;
    logic upd_en;
    logic upd_level;
  } evw_op_t;

  function automatic evw_op_t evw_decode(input logic [CTRL_W-1:0] c);
    evw_op_t op;
    op.wait_en    = c[WAIT_EN_BIT];
    op.wait_level = |c[WAIT_HI:WAIT_LO];
    op.upd_en     = c[UPD_EN_BIT];
    op.upd_level  = |c[UPD_HI:UPD_LO];
    return op;
  endfunction
endpackage

// File: rtl/evw_slot.sv
module evw_slot
  import evw_pkg::*;
#(
  parameter int N_EVENTS = 72,
  parameter int IDX_W    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic                req_valid,
  input  logic [IDX_W-1:0]    req_idx,
  input  logic [CTRL_W-1:0]   req_ctrl,
  input  logic [N_EVENTS-1:0] flags_in,
  output logic [N_EVENTS-1:0] flags_out,
  output logic                grant_o,
  output logic                busy_o,
  output logic                err_o
);
  evw_op_t    op;
  logic       in_range;
  logic       cur;
  logic [IDX_W-1:0] idx_safe;

  always_comb begin
    op        = evw_decode(req_ctrl);
    in_range  = (int'(req_idx) < N_EVENTS);
    idx_safe  = in_range ? req_idx : '0;
    cur       = flags_in[idx_safe];
    flags_out = flags_in;
    grant_o   = 1'b0;
    busy_o    = 1'b0;
    err_o     = 1'b0;
    if (active && req_valid) begin
      if (!in_range) begin
        grant_o = 1'b1;
        err_o   = 1'b1;
      end else if (!op.wait_en || (cur == op.wait_level)) begin
        grant_o = 1'b1;
        if (op.upd_en) flags_out[idx_safe] = op.upd_level;
      end else begin
        busy_o = 1'b1;
      end
    end
  end

  // R9: a bad index leaves the bank untouched
  a_r9_err_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (flags_out == flags_in));

  // R5 / R10: no wait requested means an immediate grant
  a_r5_nowait_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (active && req_valid && !req_ctrl[WAIT_EN_BIT]) |-> grant_o);
endmodule

// File: rtl/evw_flag_bank.sv
module evw_flag_bank #(
  parameter int N_EVENTS = 72
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_EVENTS-1:0] set_i,
  input  logic [N_EVENTS-1:0] upd_i,
  output logic [N_EVENTS-1:0] flags_q
);
  logic [N_EVENTS-1:0] flags_d;
  logic                flags_en;

  always_comb begin
    flags_d  = upd_i | set_i;
    flags_en = |(flags_d ^ flags_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  // R6 / R7: a source pulse always leaves its flag at 1
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/evflag_wait_unit.sv
module evflag_wait_unit
  import evw_pkg::*;
#(
  parameter int N_EVENTS  = 72,
  parameter int N_THREADS = 3,
  parameter int IDX_W     = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_EVENTS-1:0]           src_set,
  input  logic [N_THREADS-1:0]          req_valid,
  input  logic [N_THREADS*IDX_W-1:0]    req_index,
  input  logic [N_THREADS*CTRL_W-1:0]   req_ctrl,
  output logic [N_THREADS-1:0]          grant,
  output logic [N_THREADS-1:0]          busy,
  output logic [N_THREADS-1:0]          idx_err
);
  logic [1:0]          rst_sync;
  logic                rst_core_n;
  logic [N_EVENTS-1:0] flags_q;
  logic [N_EVENTS-1:0] chain [0:N_THREADS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  assign chain[0] = flags_q;

  for (genvar t = 0; t < N_THREADS; t++) begin : g_slot
    evw_slot #(.N_EVENTS(N_EVENTS), .IDX_W(IDX_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .active    (rst_core_n),
      .req_valid (req_valid[t]),
      .req_idx   (req_index[t*IDX_W +: IDX_W]),
      .req_ctrl  (req_ctrl[t*CTRL_W +: CTRL_W]),
      .flags_in  (chain[t]),
      .flags_out (chain[t+1]),
      .grant_o   (grant[t]),
      .busy_o    (busy[t]),
      .err_o     (idx_err[t])
    );
  end

  evw_flag_bank #(.N_EVENTS(N_EVENTS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .set_i   (src_set),
    .upd_i   (chain[N_THREADS]),
    .flags_q (flags_q)
  );

  // R1: the core stays idle until the synchronised reset releases
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_core_n |-> ((grant == '0) && (busy == '0)));
endmodule

// File: tb/evflag_wait_unit_test.sv
module evflag_wait_unit_test;
  localparam int NE = 72;
  localparam int NT = 3;
  localparam int IW = 7;
  localparam int NV = 12;

  localparam logic [31:0] C_SET   = 32'h8001_0000;
  localparam logic [31:0] C_CLR   = 32'h8000_0000;
  localparam logic [31:0] C_P1    = 32'h0000_8001;
  localparam logic [31:0] C_P0    = 32'h0000_8000;
  localparam logic [31:0] C_WCLR  = 32'h8000_8001;
  localparam logic [31:0] C_NOP   = 32'h0000_0000;

  // Vector table for thread 0: index, control, expected grant, expected error
  localparam logic [IW-1:0] V_IDX [NV] = '{7'd11, 7'd11, 7'd11, 7'd11, 7'd11, 7'd100,
                                         7'd39, 7'd39, 7'd65, 7'd65, 7'd65, 7'd65};
  localparam logic [31:0] V_CTRL [NV] = '{C_SET, C_P1, C_WCLR, C_P1, C_P0, C_SET,
                                          C_NOP, C_P1, C_SET, C_P1, C_CLR, C_P0};
  localparam logic V_G [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1,
                                1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic V_E [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
                                1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  // Tags per row: R5 set, R3 probe, R4 wait-clear, R4 cleared, R2 zero level,
  // R9 bad index, R10 no-op, R10 unchanged, R5 set, R3, R5 clear, R2 zero level

  logic               clk;
  logic               rst_n;
  logic [NE-1:0]      src_set;
  logic [NT-1:0]      req_valid;
  logic [NT*IW-1:0]   req_index;
  logic [NT*32-1:0]   req_ctrl;
  logic [NT-1:0]      grant;
  logic [NT-1:0]      busy;
  logic [NT-1:0]      idx_err;

  int n_checks;
  int n_fail;
  bit done;

  evflag_wait_unit #(.N_EVENTS(NE), .N_THREADS(NT), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .req_valid(req_valid),
    .req_index(req_index), .req_ctrl(req_ctrl), .grant(grant), .busy(busy),
    .idx_err(idx_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input int t, input logic v, input logic [IW-1:0] idx,
                       input logic [31:0] c);
    req_valid[t]           = v;
    req_index[t*IW +: IW]  = idx;
    req_ctrl[t*32 +: 32]   = c;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; src_set = '0; req_valid = '0; req_index = '0; req_ctrl = '0;
    repeat (2) @(negedge clk);
    // R1: no grant while in reset even for a valid no-wait request
    drive(0, 1'b1, 7'd11, C_SET);
    #5;
    chk("R1 grant in reset", 32'(grant), 32'h0);
    chk("R1 busy in reset", 32'(busy), 32'h0);
    @(negedge clk);
    drive(0, 1'b0, 7'd0, C_NOP);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: flags are 0 after reset, so a wait on level 1 blocks
    drive(0, 1'b1, 7'd11, C_P1);
    #5;
    chk("R1 flag clear after reset", 32'(grant), 32'h0);
    chk("R1 busy on blocked wait", 32'(busy), 32'h1);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(0, 1'b1, V_IDX[i], V_CTRL[i]);
      #5;
      chk($sformatf("R2-table row %0d grant", i), 32'(grant[0]), 32'(V_G[i]));
      chk($sformatf("R2-table row %0d busy", i), 32'(busy[0]), 32'(!V_G[i]));
      chk($sformatf("R9 table row %0d err", i), 32'(idx_err[0]), 32'(V_E[i]));
      @(negedge clk);
    end
    drive(0, 1'b0, 7'd0, C_NOP);
    @(negedge clk);

    // R6: pulse seen one cycle later by a waiter
    drive(0, 1'b1, 7'd13, C_P1);
    src_set[13] = 1'b1;
    #5;
    chk("R6 no grant in pulse cycle", 32'(grant[0]), 32'h0);
    @(negedge clk);
    src_set = '0;
    #5;
    chk("R6 grant after pulse", 32'(grant[0]), 32'h1);
    @(negedge clk);

    // R7: set pulse and wait-and-clear on the same flag in one cycle
    drive(0, 1'b1, 7'd14, C_SET);
    @(negedge clk);
    drive(0, 1'b1, 7'd14, C_WCLR);
    src_set[14] = 1'b1;
    #5;
    chk("R7 wait-clear granted", 32'(grant[0]), 32'h1);
    @(negedge clk);
    src_set = '0;
    drive(0, 1'b1, 7'd14, C_P1);
    #5;
    chk("R7 set wins over clear", 32'(grant[0]), 32'h1);
    @(negedge clk);

    // R8: three threads wait-and-clear on one set flag
    drive(0, 1'b1, 7'd15, C_SET);
    @(negedge clk);
    for (int t = 0; t < NT; t++) drive(t, 1'b1, 7'd15, C_WCLR);
    #5;
    chk("R8 lowest thread granted", 32'(grant), 32'h1);
    chk("R8 others busy", 32'(busy), 32'h6);
    @(negedge clk);
    drive(0, 1'b0, 7'd0, C_NOP);
    #5;
    chk("R8 flag consumed", 32'(grant), 32'h0);
    src_set[15] = 1'b1;
    @(negedge clk);
    src_set = '0;
    #5;
    chk("R8 thread 1 next", 32'(grant), 32'h2);
    chk("R8 thread 2 still busy", 32'(busy), 32'h4);
    @(negedge clk);
    req_valid = '0;

    // R9: bad index on thread 2 with no side effect on flag 0
    drive(2, 1'b1, 7'd72, C_SET);
    #5;
    chk("R9 edge index err", 32'(idx_err), 32'h4);
    chk("R9 edge index grant", 32'(grant), 32'h4);
    @(negedge clk);
    drive(2, 1'b1, 7'd0, C_P0);
    #5;
    chk("R9 flag 0 untouched", 32'(grant[2]), 32'h1);
    @(negedge clk);
    req_valid = '0;

    done = 1;
    finish_run();
  end
endmodule